// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages the page pool of a network controller's packet buffer. The buffer is divided into 256-byte pages. Each packet number is the index of the first page of the packet. A processor writes one-byte commands to the block. The commands are: allocate a run of transmit pages, clear the whole allocator, drop the head of the receive packet-number queue, or drop that head and also return its pages to the pool.

An allocation asks for N+1 contiguous pages. The block searches a free-page bitmap from page 0 upward, one page per clock, and places the request at the lowest run that fits. While the search runs, a busy bit is high, and the block ignores every command written in that time. When the search ends, a result byte shows either the packet number or a failure flag. If the interrupt enable is set, a successful allocation also raises an interrupt line. The receive side pushes packet numbers into an 8-entry queue, and the processor reads the head of that queue.

Top module: `pbuf_alloc`

## Requirements
- R1: After reset, allocResult is 8'h80, allocIrq is 0, statusWord is 0 and rxHeadValid is 0. All pages are free and the queue is empty.
- R2: The command code is cmdWord[7:5] and the size field N is cmdWord[3:1]. Code 3'b001 allocates N+1 contiguous pages at the lowest free run that fits. On success, allocResult is 8'h00 OR'd with the first page index, and that index is the packet number.
- R3: If no run of N+1 free pages exists, allocResult becomes 8'h80 (bit 7 set, low bits 0) and no page is taken.
- R4: An allocate command with N greater than 5 fails with 8'h80 on the next clock and does not raise busy.
- R5: statusWord[1] is busy. It is high from the clock after an accepted valid allocate until the clock that posts the result. The search examines one page per clock.
- R6: allocIrq rises together with a successful result when irqEn is 1. An accepted allocate command or a reset command clears it.
- R7: Any command written while busy is high has no effect.
- R8: Code 3'b010 frees all pages, empties the receive queue, sets allocResult to 8'h80, and clears allocIrq and statusWord[0].
- R9: rxPushValid with rxPushPkt appends a packet number to an 8-entry FIFO. rxHeadPkt and rxHeadValid show the oldest entry. A push into a full queue is dropped.
- R10: Code 3'b011 removes the queue head and keeps its pages allocated.
- R11: Code 3'b100 removes the queue head and frees every page of that packet.
- R12: Either remove command on an empty queue changes nothing else and sets statusWord[0]. The bit stays set until a reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | Command write strobe |
| cmdWord | input | 8 | Command code [7:5], size N [3:1] |
| irqEn | input | 1 | Enables the allocation-success interrupt |
| rxPushValid | input | 1 | Receive side pushes a packet number |
| rxPushPkt | input | 4 | Packet number to push |
| statusWord | output | 8 | Bit 1 busy, bit 0 sticky empty-pop flag |
| allocResult | output | 8 | Bit 7 fail, low bits packet number |
| allocIrq | output | 1 | Allocation-success interrupt |
| rxHeadValid | output | 1 | Receive queue holds an entry |
| rxHeadPkt | output | 4 | Packet number at the queue head |

## Verification
The hardest case to reach is proving that a command written during a search is truly ignored. The bench fills most of the pool so that the final search runs across all sixteen pages. It then writes a reset command while busy is high. A following allocation must still fail because the pool is full. Release is checked the same way: a packet is popped without being freed, and only a later allocation result can show whether its pages came back. The bench therefore chains push, pop, pop-and-free and allocate so that each release is visible through allocResult.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int PAGE_CNT = 16;
  localparam int PKT_W    = $clog2(PAGE_CNT);
  localparam int SIZE_W   = 3;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ALLOC   = 3'd1,
    CMD_RESET   = 3'd2,
    CMD_POP     = 3'd3,
    CMD_POPFREE = 3'd4
  } cmd_e;

  typedef struct packed {
    logic              clearAll;
    logic              clrIrq;
    logic              allocOk;
    logic              allocFail;
    logic [PKT_W-1:0]  allocStart;
    logic [SIZE_W-1:0] allocSize;
    logic              popHead;
    logic              freeHead;
  } strobe_t;
endpackage

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
  import pbuf_pkg::*;
#(
  parameter int MAX_SIZE = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWr,
  input  logic [7:0]          cmdWord,
  input  logic [PAGE_CNT-1:0] usedMap,
  output logic                busy,
  output strobe_t             stb
);
  localparam int RUN_W = PKT_W + 1;

  cmd_e              cmd;
  logic [SIZE_W-1:0] sizeField;
  logic              accept;
  logic              sizeOk;
  logic [PKT_W-1:0]  cursor;
  logic [RUN_W-1:0]  run, runNext, need;
  logic [SIZE_W-1:0] nReq;
  logic              hit, lastPage;

  assign cmd       = cmd_e'(cmdWord[7:5]);
  assign sizeField = cmdWord[3:1];
  assign accept    = cmdWr && !busy;
  assign sizeOk    = int'(sizeField) <= MAX_SIZE;
  assign runNext   = usedMap[cursor] ? '0 : run + 1'b1;
  assign need      = RUN_W'(nReq) + 1'b1;
  assign hit       = busy && !usedMap[cursor] && (runNext == need);
  assign lastPage  = cursor == PKT_W'(PAGE_CNT - 1);

  always_comb begin
    stb = '0;
    if (accept) begin
      case (cmd)
        CMD_ALLOC: begin
          stb.clrIrq    = 1'b1;
          stb.allocFail = !sizeOk;
        end
        CMD_RESET:   stb.clearAll = 1'b1;
        CMD_POP:     stb.popHead  = 1'b1;
        CMD_POPFREE: begin
          stb.popHead  = 1'b1;
          stb.freeHead = 1'b1;
        end
        default: ;
      endcase
    end
    if (busy) begin
      if (hit) begin
        stb.allocOk    = 1'b1;
        stb.allocStart = cursor - PKT_W'(nReq);
        stb.allocSize  = nReq;
      end else if (lastPage) begin
        stb.allocFail = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cursor <= '0;
      run    <= '0;
      nReq   <= '0;
    end else if (accept && cmd == CMD_ALLOC && sizeOk) begin
      busy   <= 1'b1;
      cursor <= '0;
      run    <= '0;
      nReq   <= sizeField;
    end else if (busy) begin
      if (hit || lastPage) begin
        busy <= 1'b0;
      end else begin
        cursor <= cursor + 1'b1;
        run    <= runNext;
      end
    end
  end
endmodule

// File: rtl/pbuf_dpath.sv
module pbuf_dpath
  import pbuf_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                irqEn,
  input  logic                rxPushValid,
  input  logic [PKT_W-1:0]    rxPushPkt,
  output logic [PAGE_CNT-1:0] usedMap,
  output logic [7:0]          allocResult,
  output logic                allocIrq,
  output logic                rxHeadValid,
  output logic [PKT_W-1:0]    rxHeadPkt,
  output logic                popEmpty
);
  localparam int PTR_W = $clog2(QDEPTH);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic [SIZE_W-1:0]   lenTab [PAGE_CNT];
  logic [PKT_W-1:0]    qMem   [QDEPTH];
  logic [PTR_W-1:0]    rdPtr, wrPtr;
  logic [CNT_W-1:0]    count;
  logic [PAGE_CNT-1:0] nextMap;
  logic                doPop, doPush;

  assign rxHeadValid = count != '0;
  assign rxHeadPkt   = qMem[rdPtr];
  assign doPop       = stb.popHead && rxHeadValid;
  assign doPush      = rxPushValid && (int'(count) < QDEPTH || doPop);

  always_comb begin
    nextMap = usedMap;
    for (int i = 0; i < PAGE_CNT; i++) begin
      if (stb.allocOk && i >= int'(stb.allocStart) &&
          i <= int'(stb.allocStart) + int'(stb.allocSize))
        nextMap[i] = 1'b1;
      if (stb.freeHead && doPop && i >= int'(rxHeadPkt) &&
          i <= int'(rxHeadPkt) + int'(lenTab[rxHeadPkt]))
        nextMap[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedMap     <= '0;
      allocResult <= 8'h80;
      allocIrq    <= 1'b0;
      popEmpty    <= 1'b0;
      rdPtr       <= '0;
      wrPtr       <= '0;
      count       <= '0;
    end else if (stb.clearAll) begin
      usedMap     <= '0;
      allocResult <= 8'h80;
      allocIrq    <= 1'b0;
      popEmpty    <= 1'b0;
      rdPtr       <= '0;
      wrPtr       <= '0;
      count       <= '0;
    end else begin
      usedMap <= nextMap;
      if (stb.clrIrq) allocIrq <= 1'b0;
      if (stb.allocOk) begin
        allocResult <= 8'(stb.allocStart);
        allocIrq    <= irqEn;
      end else if (stb.allocFail) begin
        allocResult <= 8'h80;
      end
      if (stb.popHead && !rxHeadValid) popEmpty <= 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush) wrPtr <= wrPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.allocOk) lenTab[stb.allocStart] <= stb.allocSize;
    if (doPush && !stb.clearAll) qMem[wrPtr] <= rxPushPkt;
  end
endmodule

// File: rtl/pbuf_alloc.sv
module pbuf_alloc
  import pbuf_pkg::*;
#(
  parameter int MAX_SIZE = 5,
  parameter int QDEPTH   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [7:0]       cmdWord,
  input  logic             irqEn,
  input  logic             rxPushValid,
  input  logic [PKT_W-1:0] rxPushPkt,
  output logic [7:0]       statusWord,
  output logic [7:0]       allocResult,
  output logic             allocIrq,
  output logic             rxHeadValid,
  output logic [PKT_W-1:0] rxHeadPkt
);
  strobe_t             stb;
  logic                busy, popEmpty;
  logic [PAGE_CNT-1:0] usedMap;

  pbuf_ctrl #(.MAX_SIZE(MAX_SIZE)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWord(cmdWord),
    .usedMap(usedMap), .busy(busy), .stb(stb)
  );

  pbuf_dpath #(.QDEPTH(QDEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .irqEn(irqEn),
    .rxPushValid(rxPushValid), .rxPushPkt(rxPushPkt), .usedMap(usedMap),
    .allocResult(allocResult), .allocIrq(allocIrq),
    .rxHeadValid(rxHeadValid), .rxHeadPkt(rxHeadPkt), .popEmpty(popEmpty)
  );

  assign statusWord = {6'b0, busy, popEmpty};
endmodule

// File: rtl/pbuf_alloc_chk.sv
module pbuf_alloc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWr,
  input logic [7:0] cmdWord,
  input logic       irqEn,
  input logic       rxPushValid,
  input logic [7:0] statusWord,
  input logic [7:0] allocResult,
  input logic       allocIrq,
  input logic       rxHeadValid
);
  logic busyBit;
  assign busyBit = statusWord[1];

  // R3: a failure code carries no packet number
  assert_fail_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    allocResult[7] |-> allocResult[6:0] == 7'd0);

  // R4: oversize request fails at once without a search
  assert_bad_size_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busyBit && cmdWord[7:5] == 3'b001 && cmdWord[3:1] > 3'd5)
    |=> (allocResult == 8'h80 && !statusWord[1]));

  // R6: interrupt only rises with a success code while enabled
  assert_irq_success_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(allocIrq) |-> (!allocResult[7] && $past(irqEn)));

  // R5: the interrupt is never high during a search
  assert_busy_no_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    busyBit |-> !allocIrq);

  // R8: reset command restores the idle result and empties the queue
  assert_reset_cmd_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busyBit && cmdWord[7:5] == 3'b010)
    |=> (allocResult == 8'h80 && !allocIrq && !rxHeadValid && !statusWord[0]));

  // R12: removing from an empty queue sets the sticky flag
  assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busyBit && !rxHeadValid && !rxPushValid &&
     (cmdWord[7:5] == 3'b011 || cmdWord[7:5] == 3'b100))
    |=> statusWord[0]);
endmodule

bind pbuf_alloc pbuf_alloc_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWord(cmdWord), .irqEn(irqEn),
  .rxPushValid(rxPushValid), .statusWord(statusWord),
  .allocResult(allocResult), .allocIrq(allocIrq), .rxHeadValid(rxHeadValid)
);

// File: tb/pbuf_alloc_tb_top.sv
module pbuf_alloc_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWr = 1'b0;
  logic [7:0] cmdWord = '0;
  logic       irqEn = 1'b1;
  logic       rxPushValid = 1'b0;
  logic [3:0] rxPushPkt = '0;
  logic [7:0] statusWord, allocResult;
  logic       allocIrq, rxHeadValid;
  logic [3:0] rxHeadPkt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  pbuf_alloc dut_i (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWord(cmdWord), .irqEn(irqEn),
    .rxPushValid(rxPushValid), .rxPushPkt(rxPushPkt), .statusWord(statusWord),
    .allocResult(allocResult), .allocIrq(allocIrq),
    .rxHeadValid(rxHeadValid), .rxHeadPkt(rxHeadPkt)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] cmd, logic [2:0] n);
    @(negedge clk);
    cmdWr   = 1'b1;
    cmdWord = {cmd, 1'b0, n, 1'b0};
    @(negedge clk);
    cmdWr   = 1'b0;
  endtask

  task automatic doAlloc(logic [2:0] n, logic [7:0] exp, string tag);
    wr(3'b001, n);
    tagQ.push_back(tag);
    expQ.push_back(exp);
    wait (expQ.size() == 0);
  endtask

  task automatic push(logic [3:0] pkt);
    @(negedge clk);
    rxPushValid = 1'b1;
    rxPushPkt   = pkt;
    @(negedge clk);
    rxPushValid = 1'b0;
  endtask

  // monitor: waits for the search to end, then compares the result
  initial begin
    forever begin
      wait (expQ.size() > 0);
      repeat (2) @(negedge clk);
      while (statusWord[1]) @(negedge clk);
      chk(tagQ[0], allocResult, expQ[0]);
      void'(tagQ.pop_front());
      void'(expQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 result", allocResult, 8'h80);
    chk("R1 status", statusWord, 8'h00);
    chk("R1 irq/head", {allocIrq, rxHeadValid}, 8'h00);
    rstN = 1'b1;
    doAlloc(3'd0, 8'h00, "R2 first page");
    chk("R6 irq after success", {7'b0, allocIrq}, 8'h01);
    doAlloc(3'd2, 8'h01, "R2 three pages");
    doAlloc(3'd5, 8'h04, "R2 six pages");
    doAlloc(3'd6, 8'h80, "R4 oversize");
    chk("R4 no busy", statusWord, 8'h00);
    // R5/R7: search over remaining pages; reset written while busy
    wr(3'b001, 3'd5);
    tagQ.push_back("R2 last run");
    expQ.push_back(8'h0A);
    chk("R5 busy high", {7'b0, statusWord[1]}, 8'h01);
    wr(3'b010, 3'd0);
    wait (expQ.size() == 0);
    doAlloc(3'd0, 8'h80, "R7 reset ignored, R3 pool full");
    chk("R6 irq cleared by allocate", {7'b0, allocIrq}, 8'h00);
    push(4'd1);
    push(4'd4);
    push(4'd0);
    chk("R9 head", {rxHeadValid, 3'b0, rxHeadPkt}, 8'h81);
    wr(3'b011, 3'd0);
    chk("R10 next head", {rxHeadValid, 3'b0, rxHeadPkt}, 8'h84);
    doAlloc(3'd2, 8'h80, "R10 pages kept");
    wr(3'b100, 3'd0);
    chk("R11 next head", {rxHeadValid, 3'b0, rxHeadPkt}, 8'h80);
    doAlloc(3'd5, 8'h04, "R11 pages freed");
    wr(3'b011, 3'd0);
    chk("R9 empty", {7'b0, rxHeadValid}, 8'h00);
    chk("R12 flag clear", statusWord, 8'h00);
    wr(3'b100, 3'd0);
    chk("R12 empty pop flag", statusWord, 8'h01);
    chk("R12 still empty", {7'b0, rxHeadValid}, 8'h00);
    for (int i = 0; i < 9; i++) push(4'(i));
    for (int i = 0; i < 8; i++) begin
      chk("R9 order", {rxHeadValid, 3'b0, rxHeadPkt}, 8'(8'h80 | i));
      wr(3'b011, 3'd0);
    end
    chk("R9 full push dropped", {7'b0, rxHeadValid}, 8'h00);
    push(4'd7);
    wr(3'b010, 3'd0);
    chk("R8 result", allocResult, 8'h80);
    chk("R8 status/irq/head", {statusWord[6:0], allocIrq}, 8'h00);
    chk("R8 queue empty", {7'b0, rxHeadValid}, 8'h00);
    doAlloc(3'd5, 8'h00, "R8 pool freed");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule